// File: doc/BRIEF.md
# Glitch-free system clock selector

This block picks the clock that feeds a chip's core and peripherals from three free-running sources: a fast primary oscillator, a slow secondary oscillator and an internal RC oscillator. The choice comes from a two-bit select code, a configuration bit that says what code 00 means, a flag that reports when configuration has been loaded after power-up, and a power-mode request. Until configuration has been loaded, the RC oscillator always drives the output.

Whenever the chosen source changes, the block hands the output over without a glitch. The old source is first closed in its own clock domain. The new source then opens in its own domain only after the old one has fully drained. While this happens the output clock simply pauses. The block also drives one enable per oscillator, so that sources that are not needed can be powered down. In sleep, the output stops and every oscillator is released, except that the RC oscillator can be kept alive on request, for example for a watchdog.

The select code comes from a register outside the block whose reset value is 00. The configuration-loaded flag is low in reset and rises once after it. Every control input may change at any time relative to the source clocks, and each lane synchronizes what it needs. The sources are assumed to be running and stable whenever their enable is high.

Top module: `sysclk_selector`

## Requirements
- R1: While `cfg_done_i` is 0, the output follows the RC clock and `osc_en_o` is 3'b100, whatever `sel_i`, `cfg_pri_i` and `pm_mode_i` are.
- R2: With configuration loaded and `sel_i`=00, the output follows the primary clock when `cfg_pri_i`=1 and the RC clock when `cfg_pri_i`=0.
- R3: With configuration loaded, `sel_i`=01 selects the secondary clock, and both 10 and 11 select the RC clock. `cfg_pri_i` has no effect on these codes, and moving between 10 and 11 causes no handover.
- R4: At most one source gate is ever open, and a gate opens or closes only while its own clock is low. This holds even when the selection changes again before a handover has finished.
- R5: After a change of selection, the output carries exactly two more rising edges of the old source (its first two rising edges after the request). Its next rising edge is the third or fourth rising edge of the new source counted after the old gate closed. When nothing was driving before, the count starts at the request.
- R6: `busy_o` goes high as soon as the selection changes. It falls when the new source's gate opens, which is half a new-source period before the first new rising edge on the output. When the request is sleep, it falls when the old gate closes. In steady state it is 0.
- R7: `pm_mode_i` 10 or 11 (sleep), with configuration loaded, stops the output after the handover. `osc_en_o` then becomes 3'b000, or 3'b100 while `rc_keep_i` is 1.
- R8: `osc_en_o` bit 0 is the primary enable, bit 1 the secondary enable and bit 2 the RC enable. In steady state exactly the selected source's bit is high, plus bit 2 when `rc_keep_i` is 1 or configuration is not loaded. A source that is still draining or opening keeps its bit high.
- R9: `pm_mode_i` 01 (idle) behaves like 00 (run): the selected source keeps driving and no handover starts.
- R10: A low `rst_ni` stops the output at once. After release, the RC lane opens again on its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pri_i | input | 1 | Primary oscillator clock |
| clk_sec_i | input | 1 | Secondary low-frequency oscillator clock |
| clk_rc_i | input | 1 | Internal RC oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 2 | Source select code |
| cfg_pri_i | input | 1 | Configuration bit: meaning of select code 00 |
| cfg_done_i | input | 1 | Configuration values have been loaded |
| pm_mode_i | input | 2 | Power mode: 00 run, 01 idle, 10/11 sleep |
| rc_keep_i | input | 1 | Keep the RC oscillator enabled in sleep |
| sys_clk_o | output | 1 | Gated system clock |
| busy_o | output | 1 | Handover in progress |
| osc_en_o | output | 3 | Oscillator enables {rc, sec, pri} |

## Verification
The three source clocks run at unrelated periods with edges that never coincide. Each handover is therefore checked against exact edge times computed in the bench: the two closing edges of the old source, the third or fourth edge of the new one, and the moment `busy_o` falls. The handovers covered are primary, secondary and RC among each other, into sleep, and out of sleep. The bench also applies patterns that must change nothing: a select code before configuration is loaded, `cfg_pri_i` while code 01 is chosen, the move from 10 to 11, idle mode, and `rc_keep_i` during sleep. These tell a correct decode apart from one that starts a needless handover or drops an enable. A reselection made before the previous handover has finished, and a reset in mid-run, exercise the draining interlock and the asynchronous stop.

// File: rtl/sclk_pkg.sv
`timescale 1ns/1ps
package sclk_pkg;

  localparam int unsigned SRC_COUNT = 3;

  typedef enum logic [1:0] {
    SRC_PRI  = 2'd0,
    SRC_SEC  = 2'd1,
    SRC_RC   = 2'd2,
    SRC_NONE = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    PM_RUN       = 2'd0,
    PM_IDLE      = 2'd1,
    PM_SLEEP     = 2'd2,
    PM_SLEEP_ALT = 2'd3
  } pm_e;

  // Target source from the control inputs; SRC_NONE means the output stops.
  function automatic src_e pick_source(logic [1:0] sel, logic cfg_pri,
                                       logic cfg_done, pm_e pm);
    if (!cfg_done) return SRC_RC;
    if (pm == PM_SLEEP || pm == PM_SLEEP_ALT) return SRC_NONE;
    case (sel)
      2'b00:   return cfg_pri ? SRC_PRI : SRC_RC;
      2'b01:   return SRC_SEC;
      default: return SRC_RC;
    endcase
  endfunction

endpackage

// File: rtl/sclk_rst_sync.sv
`timescale 1ns/1ps
module sclk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) q <= 1'b0;
        else          q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) q <= '0;
        else          q <= {q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_no = q[STAGES-1];
endmodule

// File: rtl/sclk_lane.sv
`timescale 1ns/1ps
// One source lane: synchronizes its open request in its own domain and
// moves the output gate on the falling edge, so the gate only moves while
// the source clock is low.
module sclk_lane #(
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_i,
  input  logic others_busy_i,
  output logic gate_o,
  output logic busy_o
);
  logic                  arm;
  logic [SYNC_DEPTH-1:0] chain;

  assign arm = want_i & ~others_busy_i;

  generate
    if (SYNC_DEPTH == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain <= 1'b0;
        else         chain <= arm;
      end
    end else begin : g_shift
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain <= '0;
        else         chain <= {chain[SYNC_DEPTH-2:0], arm};
      end
    end
  endgenerate

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_o <= 1'b0;
    else         gate_o <= chain[SYNC_DEPTH-1];
  end

  // A lane counts as busy while anything is in flight or the gate is open.
  assign busy_o = (|chain) | gate_o;
endmodule

// File: rtl/sclk_decode.sv
`timescale 1ns/1ps
module sclk_decode
  import sclk_pkg::*;
(
  input  logic [1:0]           sel_i,
  input  logic                 cfg_pri_i,
  input  logic                 cfg_done_i,
  input  logic [1:0]           pm_mode_i,
  input  logic                 rc_keep_i,
  input  logic [SRC_COUNT-1:0] lane_busy_i,
  output logic [SRC_COUNT-1:0] want_o,
  output logic [SRC_COUNT-1:0] osc_en_o
);
  src_e tgt;

  always_comb begin
    tgt = pick_source(sel_i, cfg_pri_i, cfg_done_i, pm_e'(pm_mode_i));
    for (int i = 0; i < int'(SRC_COUNT); i++) begin
      want_o[i] = (tgt == src_e'(i));
    end
    osc_en_o = want_o | lane_busy_i;
    if (rc_keep_i || !cfg_done_i) osc_en_o[SRC_RC] = 1'b1;
  end
endmodule

// File: rtl/sysclk_selector.sv
`timescale 1ns/1ps
module sysclk_selector
  import sclk_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = 2,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                 clk_pri_i,
  input  logic                 clk_sec_i,
  input  logic                 clk_rc_i,
  input  logic                 rst_ni,
  input  logic [1:0]           sel_i,
  input  logic                 cfg_pri_i,
  input  logic                 cfg_done_i,
  input  logic [1:0]           pm_mode_i,
  input  logic                 rc_keep_i,
  output logic                 sys_clk_o,
  output logic                 busy_o,
  output logic [SRC_COUNT-1:0] osc_en_o
);
  logic [SRC_COUNT-1:0] src_clk;
  logic [SRC_COUNT-1:0] dom_rst_n;
  logic [SRC_COUNT-1:0] want;
  logic [SRC_COUNT-1:0] lane_gate;
  logic [SRC_COUNT-1:0] lane_busy;
  logic [SRC_COUNT-1:0] others_busy;
  logic                 tgt_open;
  logic                 tgt_valid;

  assign src_clk = {clk_rc_i, clk_sec_i, clk_pri_i};

  sclk_decode u_decode (
    .sel_i       (sel_i),
    .cfg_pri_i   (cfg_pri_i),
    .cfg_done_i  (cfg_done_i),
    .pm_mode_i   (pm_mode_i),
    .rc_keep_i   (rc_keep_i),
    .lane_busy_i (lane_busy),
    .want_o      (want),
    .osc_en_o    (osc_en_o)
  );

  // A lane may arm only once every other lane has fully drained.
  always_comb begin
    for (int i = 0; i < int'(SRC_COUNT); i++) begin
      others_busy[i] = 1'b0;
      for (int j = 0; j < int'(SRC_COUNT); j++) begin
        if (j != i) others_busy[i] = others_busy[i] | lane_busy[j];
      end
    end
  end

  generate
    for (genvar g = 0; g < int'(SRC_COUNT); g++) begin : g_lane
      sclk_rst_sync #(.STAGES(RST_STAGES)) u_rsync (
        .clk_i   (src_clk[g]),
        .arst_ni (rst_ni),
        .rst_no  (dom_rst_n[g])
      );
      sclk_lane #(.SYNC_DEPTH(SYNC_DEPTH)) u_lane (
        .clk_i         (src_clk[g]),
        .rst_ni        (dom_rst_n[g]),
        .want_i        (want[g]),
        .others_busy_i (others_busy[g]),
        .gate_o        (lane_gate[g]),
        .busy_o        (lane_busy[g])
      );
    end
  endgenerate

  assign sys_clk_o = |(src_clk & lane_gate);

  always_comb begin
    tgt_open  = 1'b0;
    tgt_valid = |want;
    for (int i = 0; i < int'(SRC_COUNT); i++) begin
      if (want[i]) tgt_open = lane_gate[i];
    end
    busy_o = (|(lane_busy & ~want)) | (tgt_valid & ~tgt_open);
  end
endmodule

// File: rtl/sclk_checker.sv
`timescale 1ns/1ps
module sclk_checker (
  input logic       clk_pri_i,
  input logic       clk_sec_i,
  input logic       clk_rc_i,
  input logic       rst_ni,
  input logic       cfg_done_i,
  input logic [1:0] pm_mode_i,
  input logic       rc_keep_i,
  input logic       busy_o,
  input logic [2:0] osc_en_o,
  input logic [2:0] lane_gate_i
);
  AST_SINGLE_GATE: assert property (@(posedge clk_rc_i) disable iff (!rst_ni) $onehot0(lane_gate_i)); // R4
  AST_SINGLE_GATE_PRI: assert property (@(posedge clk_pri_i) disable iff (!rst_ni) $onehot0(lane_gate_i)); // R4
  AST_RC_BEFORE_CFG: assert property (@(posedge clk_rc_i) disable iff (!rst_ni) !cfg_done_i |-> (lane_gate_i[1:0] == 2'b00 && osc_en_o == 3'b100)); // R1
  AST_SLEEP_DARK: assert property (@(posedge clk_rc_i) disable iff (!rst_ni) (cfg_done_i && pm_mode_i[1] && !busy_o) |-> (lane_gate_i == 3'b000 && osc_en_o == {rc_keep_i, 2'b00})); // R7
  AST_SETTLED_DRIVES: assert property (@(posedge clk_rc_i) disable iff (!rst_ni) (!busy_o && !(cfg_done_i && pm_mode_i[1])) |-> $onehot(lane_gate_i)); // R6

  always @(lane_gate_i[0]) if (rst_ni) AST_PRI_GATE_LOW: assert (!clk_pri_i); // R4
  always @(lane_gate_i[1]) if (rst_ni) AST_SEC_GATE_LOW: assert (!clk_sec_i); // R4
  always @(lane_gate_i[2]) if (rst_ni) AST_RC_GATE_LOW: assert (!clk_rc_i); // R4
endmodule

bind sysclk_selector sclk_checker u_chk (
  .clk_pri_i   (clk_pri_i),
  .clk_sec_i   (clk_sec_i),
  .clk_rc_i    (clk_rc_i),
  .rst_ni      (rst_ni),
  .cfg_done_i  (cfg_done_i),
  .pm_mode_i   (pm_mode_i),
  .rc_keep_i   (rc_keep_i),
  .busy_o      (busy_o),
  .osc_en_o    (osc_en_o),
  .lane_gate_i (lane_gate)
);

// File: tb/sim_sysclk_selector.sv
`timescale 1ns/1ps
module sim_sysclk_selector;
  logic tb_clk = 1'b0;
  always #2 tb_clk = ~tb_clk;

  logic clk_pri, clk_sec, clk_rc;
  initial begin clk_pri = 1'b0; #0.1; forever #5  clk_pri = ~clk_pri; end
  initial begin clk_rc  = 1'b0; #0.3; forever #17 clk_rc  = ~clk_rc;  end
  initial begin clk_sec = 1'b0; #0.7; forever #37 clk_sec = ~clk_sec; end

  logic       rst_n, cfg_pri, cfg_done, rc_keep;
  logic [1:0] sel, mode;
  logic       sys_clk, busy;
  logic [2:0] osc_en;

  sysclk_selector u0 (
    .clk_pri_i(clk_pri), .clk_sec_i(clk_sec), .clk_rc_i(clk_rc),
    .rst_ni(rst_n), .sel_i(sel), .cfg_pri_i(cfg_pri), .cfg_done_i(cfg_done),
    .pm_mode_i(mode), .rc_keep_i(rc_keep),
    .sys_clk_o(sys_clk), .busy_o(busy), .osc_en_o(osc_en)
  );

  int  vectors = 0;
  int  miscmp  = 0;
  int  cyc     = 0;
  bit  done    = 0;
  bit  rec     = 0;
  longint rises[$];
  longint busy_fall = -1;

  // Bench-side reference state
  logic [1:0] m_sel, m_mode;
  logic       m_cfgpri, m_cfgdone, m_keep;

  function automatic longint now_ps();
    return longint'($realtime * 1000.0);
  endfunction

  // Source index: 0 primary, 1 secondary, 2 RC, 3 none
  function automatic longint half_ps(int s);
    case (s) 0: return 5000; 1: return 37000; default: return 17000; endcase
  endfunction
  function automatic longint base_ps(int s);
    case (s) 0: return 5100; 1: return 37700; default: return 17300; endcase
  endfunction
  function automatic longint next_rise(int s, longint t);
    longint b = base_ps(s);
    longint p = 2 * half_ps(s);
    if (t < b) return b;
    return b + ((t - b) / p + 1) * p;
  endfunction

  function automatic int exp_src();
    if (!m_cfgdone) return 2;
    if (m_mode[1]) return 3;
    case (m_sel) 2'b00: return m_cfgpri ? 0 : 2; 2'b01: return 1; default: return 2; endcase
  endfunction
  function automatic logic [2:0] exp_en();
    logic [2:0] e = 3'b000;
    int s = exp_src();
    if (s < 3) e[s] = 1'b1;
    if (m_keep || !m_cfgdone) e[2] = 1'b1;
    return e;
  endfunction
  function automatic logic src_val(int s);
    case (s) 0: return clk_pri; 1: return clk_sec; 2: return clk_rc; default: return 1'b0; endcase
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    vectors++;
    if (!ok) begin
      miscmp++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge sys_clk) if (rec) rises.push_back(now_ps());
  always @(negedge busy) busy_fall = now_ps();

  always @(posedge tb_clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      miscmp++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

  task automatic apply(logic [1:0] s, logic cp, logic cd, logic [1:0] md, logic kp);
    @(posedge tb_clk);
    m_sel = s; m_cfgpri = cp; m_cfgdone = cd; m_mode = md; m_keep = kp;
    sel = s; cfg_pri = cp; cfg_done = cd; mode = md; rc_keep = kp;
  endtask

  task automatic wait_idle(string req);
    int n = 0;
    while (busy && n < 5000) begin @(posedge tb_clk); n++; end
    chk(!busy, req, "busy settles", longint'(busy), 0);
  endtask

  // Per-cycle comparison against the reference in steady state
  task automatic steady(int n, string req);
    for (int k = 0; k < n; k++) begin
      @(negedge tb_clk);
      chk(sys_clk == src_val(exp_src()), req, "sys_clk level", longint'(sys_clk), longint'(src_val(exp_src())));
      chk(busy == 1'b0, req, "busy in steady state", longint'(busy), 0);
      chk(osc_en == exp_en(), req, "osc_en (R8)", longint'(osc_en), longint'(exp_en()));
    end
  endtask

  // Exact edge timing of one handover (R5, R6)
  task automatic handover(int old_s, string req);
    int     new_s = exp_src();
    longint t_req = now_ps();
    longint t_close = t_req;
    longint o1, o2, n1, n2, n3, n4, got;
    int     idx = 0;
    rises.delete();
    rec = 1;
    #1;
    chk(busy == 1'b1, "R6", "busy right after request", longint'(busy), 1);
    wait_idle("R6");
    repeat (40) @(posedge tb_clk);
    rec = 0;
    if (old_s < 3) begin
      o1 = next_rise(old_s, t_req);
      o2 = next_rise(old_s, o1);
      got = (rises.size() > 0) ? rises[0] : -1;
      chk(got == o1, "R5", "first closing edge of old source", got, o1);
      got = (rises.size() > 1) ? rises[1] : -1;
      chk(got == o2, "R5", "second closing edge of old source", got, o2);
      t_close = o2 + half_ps(old_s);
      idx = 2;
    end
    if (new_s < 3) begin
      n1 = next_rise(new_s, t_close);
      n2 = next_rise(new_s, n1);
      n3 = next_rise(new_s, n2);
      n4 = next_rise(new_s, n3);
      got = (rises.size() > idx) ? rises[idx] : -1;
      chk(got == n3 || got == n4, "R5", "first edge of new source", got, n3);
      chk(busy_fall == got - half_ps(new_s), "R6", "busy fall time", busy_fall, got - half_ps(new_s));
    end else begin
      chk(rises.size() == idx, "R7", "edges after sleep request", rises.size(), idx);
      chk(busy_fall == t_close, "R6", "busy fall time into sleep", busy_fall, t_close);
    end
    chk(1'b1, req, "handover done", 0, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    sel = 2'b00; cfg_pri = 1'b1; cfg_done = 1'b0; mode = 2'b00; rc_keep = 1'b0;
    m_sel = 2'b00; m_cfgpri = 1'b1; m_cfgdone = 1'b0; m_mode = 2'b00; m_keep = 1'b0;
    repeat (5) @(posedge tb_clk);
    for (int k = 0; k < 20; k++) begin
      @(negedge tb_clk);
      chk(sys_clk == 1'b0, "R10", "output held in reset", longint'(sys_clk), 0);
    end
    chk(osc_en == 3'b100, "R1", "enables in reset", longint'(osc_en), 4);

    @(posedge tb_clk) rst_n = 1'b1;
    wait_idle("R10");
    steady(120, "R1");
    apply(2'b01, 1'b0, 1'b0, 2'b00, 1'b0);      // R1: select ignored before config
    steady(120, "R1");

    apply(2'b00, 1'b1, 1'b1, 2'b00, 1'b0);  handover(2, "R2");  steady(120, "R2");
    apply(2'b00, 1'b0, 1'b1, 2'b00, 1'b0);  handover(0, "R2");  steady(120, "R2");
    apply(2'b01, 1'b0, 1'b1, 2'b00, 1'b0);  handover(2, "R3");  steady(120, "R3");
    apply(2'b01, 1'b1, 1'b1, 2'b00, 1'b0);  steady(120, "R3");  // cfg bit ignored
    apply(2'b10, 1'b1, 1'b1, 2'b00, 1'b0);  handover(1, "R3");  steady(120, "R3");
    apply(2'b11, 1'b1, 1'b1, 2'b00, 1'b0);  steady(120, "R3");  // 10 -> 11 no handover
    apply(2'b00, 1'b1, 1'b1, 2'b00, 1'b0);  handover(2, "R2");  steady(120, "R2");
    apply(2'b00, 1'b1, 1'b1, 2'b01, 1'b0);  steady(120, "R9");  // idle keeps primary
    apply(2'b00, 1'b1, 1'b1, 2'b10, 1'b0);  handover(0, "R7");  steady(120, "R7");
    apply(2'b00, 1'b1, 1'b1, 2'b10, 1'b1);  steady(120, "R7");  // RC kept alive
    apply(2'b00, 1'b1, 1'b1, 2'b11, 1'b0);  steady(120, "R7");
    apply(2'b00, 1'b1, 1'b1, 2'b00, 1'b0);  handover(3, "R2");  steady(120, "R2");

    // R4: reselect before the previous handover has finished
    apply(2'b01, 1'b1, 1'b1, 2'b00, 1'b0);
    repeat (3) @(posedge tb_clk);
    apply(2'b10, 1'b1, 1'b1, 2'b00, 1'b0);
    wait_idle("R4");
    steady(120, "R4");

    // R10: reset in mid-run
    @(posedge tb_clk);
    rst_n = 1'b0; cfg_done = 1'b0; m_cfgdone = 1'b0;
    #1;
    chk(sys_clk == 1'b0, "R10", "output stops at reset", longint'(sys_clk), 0);
    for (int k = 0; k < 10; k++) begin
      @(negedge tb_clk);
      chk(sys_clk == 1'b0, "R10", "output held in reset", longint'(sys_clk), 0);
    end
    @(posedge tb_clk) rst_n = 1'b1;
    wait_idle("R10");
    steady(120, "R10");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule